// File: doc/BRIEF.md
# Snooping Bit-Rate and Frame Timer

This block sits next to a serial controller on a shared CPU bus and watches the CPU's writes to that controller. It never receives its own configuration. Instead it keeps private copies of the controller's line settings: the rate code, word length, extra stop bit and parity enable. It turns those copies into two things. The first is a bit-rate tick, made by dividing a 1.8432 MHz reference enable. The second is a character frame length in bits. When the CPU writes a byte to the controller's transmit data register, the block times one full frame in ticks. It then raises a one-cycle frame-done pulse and a sticky interrupt, which software can use in place of the controller's unreliable transmit-empty status.

The reference is never used directly as the bit clock. A counter that advances only on reference enables is compared with a terminal count taken from a lookup of the rate code. Rate code zero selects an external clock input divided by sixteen. The bus side has no handshake: every write is seen in the cycle it is presented, and the block cannot stall the CPU. All pins are plain control and status signals. The block carries no data stream, so there is no back-pressure to manage.

Top module: `baud_frame_snoop`

## Requirements
- R1: The internal divider advances only in cycles where `ref_en` is high. With `ref_en` high every cycle, ticks are exactly one divisor apart. With `ref_en` high every other cycle, they are twice the divisor apart.
- R2: The line-setting copies change only on a bus write with `reg_sel` = 3 (control byte) or `reg_sel` = 2 (command byte). Writes with `reg_sel` = 1 (status) or `reg_sel` = 0 (transmit data) leave rate, word length, stop bits and parity unchanged.
- R3: Control bits 3:0 are the rate code. Codes 1 to 15 give a tick every 36864, 24576, 16769, 13696, 12288, 6144, 3072, 1536, 1024, 768, 512, 384, 256, 192 and 96 reference enables respectively.
- R4: Rate code 0 makes the tick come from `ext_clk_en`, once every 16 of its high cycles, and `ref_en` then has no effect on the tick.
- R5: Frame length is 1 start bit, plus the data bits, plus a parity bit, plus the stop bits. Control bits 6:5 select the data bits: 00 gives 8, 01 gives 7, 10 gives 6 and 11 gives 5. Control bit 7 set gives 2 stop bits instead of 1. Command bit 5 set adds the parity bit.
- R6: A transmit data write (`reg_sel` = 0) restarts the divider phase and the frame count. With divisor D and frame length N, `frame_done` is high for exactly one cycle, in the cycle that follows clock edge number N×D after the write edge. A further transmit data write before that point restarts the count, and the earlier frame gives no pulse.
- R7: `irq` rises together with `frame_done` and stays high until a cycle with `irq_ack` high. If a frame ends in the same cycle as an acknowledge, the new frame end wins.
- R8: Synchronous active-high reset sets the control copy to 0x01 (rate code 1, 8 data bits, 1 stop bit) and clears parity. Both `irq` and `frame_done` are low after reset.
- R9: A control write restarts the divider phase. With `ref_en` high every cycle, the first tick comes D−1 edges after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | CPU write strobe to the companion controller |
| reg_sel | input | 2 | Controller register select: 0 transmit data, 1 status, 2 command, 3 control |
| bus_data | input | 8 | CPU write data |
| ref_en | input | 1 | One-cycle enable at the 1.8432 MHz reference rate |
| ext_clk_en | input | 1 | One-cycle enable from the external clock input |
| irq_ack | input | 1 | Clears the pending frame interrupt |
| bit_tick | output | 1 | One pulse per serial bit period |
| frame_done | output | 1 | One-cycle pulse when a timed frame ends |
| irq | output | 1 | Sticky frame-complete interrupt |

## Verification
With `ref_en` high every cycle, a control write at edge w gives its first `bit_tick` in the cycle after edge w+D−1, and later ticks follow every D cycles. A transmit write at edge w gives `frame_done` in the cycle after edge w+N×D. `irq` drops in the cycle after the acknowledge edge. The driver records the edge number of each transmit write and queues w+N×D, computing N and D from the line settings it wrote. A monitor samples on the falling edge and compares the cycle of each `frame_done` with the head of that queue. It counts any missing pulse or extra pulse as a miscompare. Tick gaps and periods are timed with the same edge counter, so each result is checked only in the cycle it is due.

// File: rtl/baud_snoop_pkg.sv
package baud_snoop_pkg;

  localparam int DIV_W = 16;

  typedef enum logic [1:0] {
    SEL_TXDATA  = 2'd0,
    SEL_STATUS  = 2'd1,
    SEL_COMMAND = 2'd2,
    SEL_CONTROL = 2'd3
  } reg_sel_e;

  // reference enables per bit, for the 1.8432 MHz reference
  function automatic logic [DIV_W-1:0] rate_divisor(input logic [3:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      4'd1:    d = 16'd36864;
      4'd2:    d = 16'd24576;
      4'd3:    d = 16'd16769;
      4'd4:    d = 16'd13696;
      4'd5:    d = 16'd12288;
      4'd6:    d = 16'd6144;
      4'd7:    d = 16'd3072;
      4'd8:    d = 16'd1536;
      4'd9:    d = 16'd1024;
      4'd10:   d = 16'd768;
      4'd11:   d = 16'd512;
      4'd12:   d = 16'd384;
      4'd13:   d = 16'd256;
      4'd14:   d = 16'd192;
      4'd15:   d = 16'd96;
      default: d = 16'd1;  // code 0 uses the external path
    endcase
    return d;
  endfunction

  function automatic logic [3:0] frame_bits(input logic [7:0] ctrl, input logic par_en);
    return 4'd1 + (4'd8 - {2'b00, ctrl[6:5]}) + {3'b000, par_en}
           + 4'd1 + {3'b000, ctrl[7]};
  endfunction

endpackage

// File: rtl/snoop_regs.sv
module snoop_regs
  import baud_snoop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] bus_data,
  output logic [7:0] ctrl_q,
  output logic       par_en_q,
  output logic       ctrl_wr,
  output logic       tx_wr
);
  reg_sel_e sel;
  logic     cmd_wr;

  assign sel     = reg_sel_e'(reg_sel);
  assign ctrl_wr = bus_wr && (sel == SEL_CONTROL);
  assign cmd_wr  = bus_wr && (sel == SEL_COMMAND);
  assign tx_wr   = bus_wr && (sel == SEL_TXDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= 8'h01;
      par_en_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q   <= bus_data;
      if (cmd_wr)  par_en_q <= bus_data[5];
    end
  end

  // R2: the copies move only on the two snooped registers
  a_r2_ctrl_snoop_only: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && reg_sel == 2'd3) |=> $stable(ctrl_q));
  a_r2_cmd_snoop_only: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && reg_sel == 2'd2) |=> $stable(par_en_q));

endmodule

// File: rtl/line_lut.sv
module line_lut
  import baud_snoop_pkg::*;
#(
  parameter int FRAME_W = 4
) (
  input  logic [7:0]       ctrl_q,
  input  logic             par_en_q,
  output logic [DIV_W-1:0] term,
  output logic             ext_mode,
  output logic [FRAME_W-1:0] frame_len
);
  logic [DIV_W-1:0] divisor;

  always_comb begin
    divisor   = rate_divisor(ctrl_q[3:0]);
    term      = divisor - {{(DIV_W-1){1'b0}}, 1'b1};
    ext_mode  = (ctrl_q[3:0] == 4'd0);
    frame_len = FRAME_W'(frame_bits(ctrl_q, par_en_q));
  end

endmodule

// File: rtl/rate_divider.sv
module rate_divider
  import baud_snoop_pkg::*;
#(
  parameter int EXT_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             ref_en,
  input  logic             ext_en,
  input  logic             ext_mode,
  input  logic [DIV_W-1:0] term,
  output logic             tick
);
  localparam int EXT_W = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
  localparam logic [EXT_W-1:0] EXT_LAST = EXT_W'(EXT_DIV - 1);

  logic [DIV_W-1:0] div_cnt;
  logic [EXT_W-1:0] ext_cnt;
  logic             int_hit;
  logic             ext_hit;

  assign int_hit = ref_en && (div_cnt == term);
  assign ext_hit = ext_en && (ext_cnt == EXT_LAST);
  assign tick    = ext_mode ? ext_hit : int_hit;

  always_ff @(posedge clk) begin
    if (rst || restart)  div_cnt <= '0;
    else if (ref_en)     div_cnt <= (div_cnt == term) ? '0 : div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || restart)  ext_cnt <= '0;
    else if (ext_en)     ext_cnt <= (ext_cnt == EXT_LAST) ? '0 : ext_cnt + 1'b1;
  end

  // R1: no reference enable, no progress
  a_r1_hold_without_ref: assert property (@(posedge clk) disable iff (rst)
    !ref_en && !restart |=> $stable(div_cnt));
  // R9: a restart leaves the divider at phase zero
  a_r9_restart_phase: assert property (@(posedge clk) disable iff (rst)
    restart |=> div_cnt == '0 && ext_cnt == '0);
  // R4: in external mode the tick needs an external enable
  a_r4_ext_needs_edge: assert property (@(posedge clk) disable iff (rst)
    ext_mode && !ext_en |-> !tick);

endmodule

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_len,
  input  logic               tick,
  input  logic               ack,
  output logic               frame_done,
  output logic               irq
);
  localparam logic [FRAME_W-1:0] ONE = FRAME_W'(1);

  logic [FRAME_W-1:0] remaining;
  logic               last_bit;

  assign last_bit = tick && (remaining == ONE) && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining  <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= last_bit;
      if (start)
        remaining <= frame_len;
      else if (tick && remaining != '0)
        remaining <= remaining - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           irq <= 1'b0;
    else if (last_bit) irq <= 1'b1;
    else if (ack)      irq <= 1'b0;
  end

  // R6: the frame end is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  // R7: the interrupt accompanies the pulse
  a_r7_done_raises_irq: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> irq);
  // R7: without an acknowledge the interrupt stays
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    irq && !ack |=> irq);

endmodule

// File: rtl/baud_frame_snoop.sv
module baud_frame_snoop
  import baud_snoop_pkg::*;
#(
  parameter int EXT_DIV = 16,
  parameter int FRAME_W = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] bus_data,
  input  logic       ref_en,
  input  logic       ext_clk_en,
  input  logic       irq_ack,
  output logic       bit_tick,
  output logic       frame_done,
  output logic       irq
);
  logic [7:0]         ctrl_q;
  logic               par_en_q;
  logic               ctrl_wr;
  logic               tx_wr;
  logic [DIV_W-1:0]   term;
  logic               ext_mode;
  logic [FRAME_W-1:0] frame_len;

  snoop_regs u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .reg_sel(reg_sel),
    .bus_data(bus_data), .ctrl_q(ctrl_q), .par_en_q(par_en_q),
    .ctrl_wr(ctrl_wr), .tx_wr(tx_wr)
  );

  line_lut #(.FRAME_W(FRAME_W)) u_lut (
    .ctrl_q(ctrl_q), .par_en_q(par_en_q), .term(term),
    .ext_mode(ext_mode), .frame_len(frame_len)
  );

  rate_divider #(.EXT_DIV(EXT_DIV)) u_div (
    .clk(clk), .rst(rst), .restart(ctrl_wr || tx_wr), .ref_en(ref_en),
    .ext_en(ext_clk_en), .ext_mode(ext_mode), .term(term), .tick(bit_tick)
  );

  frame_timer #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst(rst), .start(tx_wr), .frame_len(frame_len),
    .tick(bit_tick), .ack(irq_ack), .frame_done(frame_done), .irq(irq)
  );

endmodule

// File: tb/baud_frame_snoop_bench.sv
module baud_frame_snoop_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] reg_sel = 2'd1;
  logic [7:0] bus_data = 8'h00;
  logic       ref_en = 1'b1;
  logic       ext_clk_en = 1'b1;
  logic       irq_ack = 1'b0;
  logic       bit_tick, frame_done, irq;

  int  cyc = 0;
  int  vectors = 0;
  int  fails = 0;
  int  last_wr = 0;
  bit  half_rate = 1'b0;
  int  exp_q[$];

  localparam int LIMIT = 190000;

  baud_frame_snoop u_baud_frame_snoop (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .reg_sel(reg_sel),
    .bus_data(bus_data), .ref_en(ref_en), .ext_clk_en(ext_clk_en),
    .irq_ack(irq_ack), .bit_tick(bit_tick), .frame_done(frame_done), .irq(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      @(posedge clk);
      ref_en <= half_rate ? ~ref_en : 1'b1;
    end
  end

  function automatic int model_div(input logic [7:0] c);
    case (c[3:0])
      4'd0: return 16;       4'd1: return 36864;  4'd2: return 24576;
      4'd3: return 16769;    4'd4: return 13696;  4'd5: return 12288;
      4'd6: return 6144;     4'd7: return 3072;   4'd8: return 1536;
      4'd9: return 1024;     4'd10: return 768;   4'd11: return 512;
      4'd12: return 384;     4'd13: return 256;   4'd14: return 192;
      default: return 96;
    endcase
  endfunction

  function automatic int model_bits(input logic [7:0] c, input bit par);
    return 1 + (8 - int'(c[6:5])) + (par ? 1 : 0) + (c[7] ? 2 : 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; reg_sel = sel; bus_data = d;
    @(negedge clk);
    bus_wr = 1'b0; reg_sel = 2'd1;
    last_wr = cyc;
  endtask

  task automatic next_tick(output int t);
    do @(negedge clk); while (!bit_tick);
    t = cyc;
  endtask

  task automatic send_frame(input logic [7:0] c, input bit par);
    bus_write(2'd0, 8'hA5);
    exp_q.push_back(last_wr + model_bits(c, par) * model_div(c));
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic period_check(input string req, input int exp);
    int t1, t2;
    next_tick(t1);
    next_tick(t2);
    check(t2 - t1 == exp, req, t2 - t1, exp);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (frame_done) begin
        if (exp_q.size() == 0) check(1'b0, "R6 unexpected frame_done", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(cyc == e, "R6 frame_done cycle", cyc, e);
        end
      end
      if (exp_q.size() != 0 && cyc > exp_q[0]) begin
        int e;
        e = exp_q.pop_front();
        check(1'b0, "R6 missing frame_done", cyc, e);
      end
    end
    if (cyc > LIMIT) begin
      fails++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int t, w;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R8 irq after reset", irq, 0);
    check(frame_done == 1'b0, "R8 frame_done after reset", frame_done, 0);
    period_check("R8 default divisor (R3 code 1)", 36864);

    // R9/R3: 19200 rate, first tick phase and period
    bus_write(2'd3, 8'h0F);
    w = last_wr;
    next_tick(t);
    check(t - w == 95, "R9 first tick after control write", t - w, 95);
    period_check("R3 code 15 period", 96);

    // R6/R7: 8N1 frame, sticky irq, ack
    send_frame(8'h0F, 1'b0);
    drain();
    repeat (5) @(negedge clk);
    check(irq == 1'b1, "R7 irq held before ack", irq, 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check(irq == 1'b0, "R7 irq cleared by ack", irq, 0);

    // R5: 5 data, parity, 2 stop
    bus_write(2'd2, 8'h20);
    bus_write(2'd3, 8'hEF);
    send_frame(8'hEF, 1'b1);
    drain();

    // R5/R3: 6 data, parity, 1 stop at code 14
    bus_write(2'd3, 8'h4E);
    period_check("R3 code 14 period", 192);
    send_frame(8'h4E, 1'b1);
    drain();

    // R2: status writes leave the copies alone
    bus_write(2'd1, 8'h00);
    bus_write(2'd1, 8'hFF);
    period_check("R2 rate kept after status writes", 192);
    send_frame(8'h4E, 1'b1);
    drain();

    // R1: reference enable every other cycle
    half_rate = 1'b1;
    period_check("R1 half-rate reference period", 384);
    half_rate = 1'b0;
    repeat (2) @(negedge clk);

    // R4: external clock divided by 16
    bus_write(2'd2, 8'h00);
    bus_write(2'd3, 8'h00);
    period_check("R4 external divide period", 16);
    send_frame(8'h00, 1'b0);
    drain();
    ext_clk_en = 1'b0;
    repeat (40) @(negedge clk);
    check(bit_tick == 1'b0, "R4 no tick without external edge", bit_tick, 0);
    ext_clk_en = 1'b1;

    // R3: further table entries
    bus_write(2'd3, 8'h0D);
    period_check("R3 code 13 period", 256);
    bus_write(2'd3, 8'h09);
    period_check("R3 code 9 period", 1024);

    // R6: restart mid-frame; only the second frame completes
    bus_write(2'd3, 8'h0F);
    bus_write(2'd0, 8'h11);
    repeat (300) @(negedge clk);
    send_frame(8'h0F, 1'b0);
    drain();
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule